// File: doc/BRIEF.md
# Cascaded Interrupt Controller with Acknowledge Sequencer

This block joins two eight-line priority cores, a primary and a secondary, into one interrupt controller facing the processor. The sixteen request inputs are split by controller: lines 0 to 7 feed the primary core and lines 8 to 15 feed the secondary core, so the controller index is the line number shifted right by three. The secondary core's pending state is presented on primary line 2. A pending secondary request therefore competes in the primary core at the priority of line 2.

The processor sees one interrupt line. When the interrupt is taken, the processor pulses the acknowledge strobe for a single cycle. On that strobe the block picks the winning line, clears it where that applies, and loads an 8-bit vector register. The vector is built from a per-controller base, which holds only its top five bits, and the winning line number. If nothing is pending at acknowledge time, the block returns the spurious code, which is line 7 of the primary controller.

Each core uses fixed priority, with the lowest line number winning, and clears its in-service state automatically on acknowledge. A small configuration write port loads the two vector bases and the two trigger-mode registers. Each trigger-mode register has a fixed set of writable bits.

Top module: `cascade_pic`

## Requirements
- R1: While `rst_ni` is low and after it is released, `int_o` is 0, `vector_o` is 8'h00, and every line is in edge mode.
- R2: In edge mode, a line becomes pending in the cycle after its input goes from 0 to 1. It stays pending after the input falls, and one acknowledge that selects it clears it.
- R3: A line whose trigger bit is 1 (level mode) is pending exactly while its input was high at the previous edge. Acknowledging it does not clear it.
- R4: Within each controller, the lowest-numbered pending line wins.
- R5: An acknowledge whose primary winner is line n (n not 2) loads `vector_o` = {primary base[7:3], n}. The value appears in the cycle after the strobe and is held until the next strobe.
- R6: Any pending secondary line makes primary line 2 pending. On acknowledge with primary winner 2, the secondary winner m is acknowledged and `vector_o` = {secondary base[7:3], m}.
- R7: An acknowledge with no primary winner loads `vector_o` = {primary base[7:3], 3'd7} and changes no pending state.
- R8: A configuration write with `cfg_sel_i` = 0 loads the primary base and `cfg_sel_i` = 1 loads the secondary base. Only data bits 7:3 are kept, and vector bits 2:0 always carry the line number.
- R9: `cfg_sel_i` = 2 writes the primary trigger register through mask 8'hF8, and `cfg_sel_i` = 3 writes the secondary trigger register through mask 8'hDE. Masked-out bits (primary lines 0 to 2, secondary lines 8 and 13) stay in edge mode.
- R10: Input `irq_req_i[2]` has no effect, because primary line 2 is driven only by the secondary core.
- R11: After an acknowledge, `int_o` reflects the remaining pending lines in the very next cycle, so chained requests keep `int_o` high without a gap.
- R12: A rising edge on an edge-mode line in the same cycle that the line is acknowledged leaves the line pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 16 | Request lines; 7:0 primary, 15:8 secondary |
| ack_i | input | 1 | Single-cycle acknowledge strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 2 | 0 primary base, 1 secondary base, 2 primary trigger, 3 secondary trigger |
| cfg_wdata_i | input | 8 | Configuration write data |
| int_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Vector captured at the last acknowledge |

## Verification
Two functions can land in the same clock edge: an acknowledge clearing a line, and that same line's request logic setting it again. The second can come from a fresh rising edge or from a level input still held high. The directed cases provoke both forms by returning an edge line's input to 1 exactly on the strobe cycle, and by acknowledging held level lines repeatedly. A seeded random phase also overlaps strobes with request toggles and trigger rewrites. A cycle-level bench model, written from the requirements, predicts the outcome: the line stays pending, and `int_o` stays high in the following cycle.

// File: rtl/cascade_pic_pkg.sv
package cascade_pic_pkg;
  localparam int LINES      = 8;
  localparam int LINE_W     = $clog2(LINES);
  localparam int VEC_W      = 8;
  localparam int BASE_W     = VEC_W - LINE_W;
  localparam int CASC_LINE  = 2;
  localparam logic [LINES-1:0] PRI_TRIG_MASK = 8'hF8;
  localparam logic [LINES-1:0] SEC_TRIG_MASK = 8'hDE;

  typedef enum logic [1:0] {
    CFG_PRI_BASE = 2'd0,
    CFG_SEC_BASE = 2'd1,
    CFG_PRI_TRIG = 2'd2,
    CFG_SEC_TRIG = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/prio_enc.sv
module prio_enc #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_core.sv
module irq_core #(
  parameter int               LINES     = 8,
  parameter logic [LINES-1:0] TRIG_MASK = '1,
  parameter bit               CASC_EN   = 1'b0,
  parameter int               CASC_LINE = 2,
  localparam int              LW        = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] req_i,
  input  logic             casc_i,
  input  logic             trig_we_i,
  input  logic [LINES-1:0] trig_wdata_i,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [LW-1:0]    win_o
);
  // line fed by cascade input instead of a request pin
  localparam logic [LINES-1:0] CASC_MASK =
    CASC_EN ? (LINES'(1) << CASC_LINE) : '0;

  logic [LINES-1:0] irr_q, irr_d, last_q, trig_q, eff, clr;

  assign eff = (irr_q & ~CASC_MASK) | (CASC_MASK & {LINES{casc_i}});

  prio_enc #(.N(LINES), .W(LW)) u_enc (
    .req_i (eff),
    .any_o (pend_o),
    .idx_o (win_o)
  );

  always_comb begin
    clr   = (ack_i && pend_o) ? ((LINES'(1) << win_o) & ~trig_q) : '0;
    irr_d = (trig_q & req_i)
          | (~trig_q & ((irr_q & ~clr) | (req_i & ~last_q)));
    irr_d = irr_d & ~CASC_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      last_q <= '0;
      trig_q <= '0;
    end else begin
      irr_q  <= irr_d;
      last_q <= req_i;
      if (trig_we_i) trig_q <= trig_wdata_i & TRIG_MASK;
    end
  end

  // edge line selected by an acknowledge, with no new edge, is gone next cycle
  a_r2_edge_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_o && !trig_q[win_o] && !CASC_MASK[win_o]
      && !(req_i[win_o] && !last_q[win_o]))
    |=> !irr_q[$past(win_o)]);

  // level lines track the sampled input, acknowledge or not
  a_r3_level_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((irr_q ^ $past(req_i)) & $past(trig_q) & ~CASC_MASK) == '0));

  // a new edge on an edge line always lands, even on an acknowledge cycle
  a_r12_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((irr_q & $past(~trig_q & req_i & ~last_q & ~CASC_MASK))
               == $past(~trig_q & req_i & ~last_q & ~CASC_MASK))));
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
  import cascade_pic_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [15:0]  irq_req_i,
  input  logic         ack_i,
  input  logic         cfg_we_i,
  input  logic [1:0]   cfg_sel_i,
  input  logic [7:0]   cfg_wdata_i,
  output logic         int_o,
  output logic [7:0]   vector_o
);
  logic [BASE_W-1:0] pri_base_q, sec_base_q;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic              pri_pend, sec_pend, sec_ack, pri_tw, sec_tw;
  logic [LINE_W-1:0] pri_win, sec_win;

  assign pri_tw  = cfg_we_i && (cfg_sel_e'(cfg_sel_i) == CFG_PRI_TRIG);
  assign sec_tw  = cfg_we_i && (cfg_sel_e'(cfg_sel_i) == CFG_SEC_TRIG);
  assign sec_ack = ack_i && pri_pend && (pri_win == LINE_W'(CASC_LINE));

  irq_core #(
    .LINES(LINES), .TRIG_MASK(SEC_TRIG_MASK), .CASC_EN(1'b0), .CASC_LINE(CASC_LINE)
  ) u_sec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (irq_req_i[2*LINES-1:LINES]),
    .casc_i       (1'b0),
    .trig_we_i    (sec_tw),
    .trig_wdata_i (cfg_wdata_i),
    .ack_i        (sec_ack),
    .pend_o       (sec_pend),
    .win_o        (sec_win)
  );

  irq_core #(
    .LINES(LINES), .TRIG_MASK(PRI_TRIG_MASK), .CASC_EN(1'b1), .CASC_LINE(CASC_LINE)
  ) u_pri (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (irq_req_i[LINES-1:0]),
    .casc_i       (sec_pend),
    .trig_we_i    (pri_tw),
    .trig_wdata_i (cfg_wdata_i),
    .ack_i        (ack_i),
    .pend_o       (pri_pend),
    .win_o        (pri_win)
  );

  always_comb begin
    vec_d = vec_q;
    if (ack_i) begin
      if (!pri_pend)                               vec_d = {pri_base_q, LINE_W'(LINES - 1)};
      else if (pri_win != LINE_W'(CASC_LINE))      vec_d = {pri_base_q, pri_win};
      else if (sec_pend)                           vec_d = {sec_base_q, sec_win};
      else                                         vec_d = {sec_base_q, LINE_W'(LINES - 1)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_base_q <= '0;
      sec_base_q <= '0;
      vec_q      <= '0;
    end else begin
      vec_q <= vec_d;
      if (cfg_we_i && cfg_sel_e'(cfg_sel_i) == CFG_PRI_BASE) pri_base_q <= cfg_wdata_i[VEC_W-1:LINE_W];
      if (cfg_we_i && cfg_sel_e'(cfg_sel_i) == CFG_SEC_BASE) sec_base_q <= cfg_wdata_i[VEC_W-1:LINE_W];
    end
  end

  assign int_o    = pri_pend;
  assign vector_o = vec_q;

  a_r7_spurious_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o) |=> (vector_o == {$past(pri_base_q), 3'd7}));

  a_r6_cascade_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && pri_win == LINE_W'(CASC_LINE))
    |=> (vector_o[VEC_W-1:LINE_W] == $past(sec_base_q)));

  a_r6_sec_raises_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pend |-> int_o);

  a_r5_vector_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> $stable(vector_o));
endmodule

// File: tb/cascade_pic_test.sv
module cascade_pic_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_v = '0;
  logic        ack = 1'b0, we = 1'b0;
  logic [1:0]  sel = '0;
  logic [7:0]  wd = '0;
  logic        int_w;
  logic [7:0]  vec_w;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  // bench model state
  logic [7:0] m_irr = '0, s_irr = '0, m_last = '0, s_last = '0, m_trig = '0, s_trig = '0;
  logic [4:0] mb = '0, sb = '0;
  logic [7:0] vec_e = '0;
  logic       int_e = 1'b0;

  always #5 clk = ~clk;

  cascade_pic uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req_v), .ack_i(ack),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wd),
    .int_o(int_w), .vector_o(vec_w)
  );

  function automatic logic [2:0] lowest(input logic [7:0] v);
    logic [2:0] r = 3'd0;
    for (int i = 7; i >= 0; i--) if (v[i]) r = 3'(i);
    return r;
  endfunction

  function automatic logic [7:0] next_irr(input logic [7:0] irr, input logic [7:0] trig,
                                          input logic [7:0] rq, input logic [7:0] last,
                                          input logic [7:0] clr);
    return (trig & rq) | (~trig & ((irr & ~clr) | (rq & ~last)));
  endfunction

  task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp_v, input string what);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", t, what, act, exp_v);
    end
  endtask

  task automatic step(input bit a, input bit w, input logic [1:0] s, input logic [7:0] d);
    logic [7:0] meff, mclr, sclr;
    logic [2:0] mw, sw;
    @(negedge clk);
    ack = a; we = w; sel = s; wd = d;
    meff = m_irr | {5'd0, |s_irr, 2'd0};
    mclr = '0; sclr = '0;
    if (a) begin
      if (meff == 0) vec_e = {mb, 3'd7};
      else begin
        mw = lowest(meff);
        if (mw == 3'd2) begin
          sw = lowest(s_irr);
          vec_e = {sb, sw};
          if (!s_trig[sw]) sclr = 8'(1) << sw;
        end else begin
          vec_e = {mb, mw};
          if (!m_trig[mw]) mclr = 8'(1) << mw;
        end
      end
    end
    m_irr = next_irr(m_irr, m_trig, req_v[7:0], m_last, mclr) & 8'hFB;
    s_irr = next_irr(s_irr, s_trig, req_v[15:8], s_last, sclr);
    m_last = req_v[7:0];
    s_last = req_v[15:8];
    if (w) begin
      case (s)
        2'd0: mb = d[7:3];
        2'd1: sb = d[7:3];
        2'd2: m_trig = d & 8'hF8;
        default: s_trig = d & 8'hDE;
      endcase
    end
    int_e = (|m_irr) | (|s_irr);
    @(posedge clk);
    #1;
    check(tag, {7'd0, int_w}, {7'd0, int_e}, "int_o");
    check(tag, vec_w, vec_e, "vector_o");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 8'd0);
  endtask

  task automatic drain();
    for (int i = 0; i < 20; i++) if (int_e) step(1'b1, 1'b0, 2'd0, 8'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1", {7'd0, int_w}, 8'd0, "int_o in reset");
    check("R1", vec_w, 8'd0, "vector_o in reset");
    @(negedge clk); rst_n = 1'b1;
    tag = "R1"; idle(2);

    // R8: base low bits dropped
    tag = "R8";
    step(1'b0, 1'b1, 2'd0, 8'h27);
    step(1'b0, 1'b1, 2'd1, 8'h7F);
    // R7: spurious acknowledge
    tag = "R7";
    step(1'b1, 1'b0, 2'd0, 8'd0);
    check("R7", vec_w, 8'h27, "spurious vector");
    check("R7", {7'd0, int_w}, 8'd0, "int after spurious");

    // R2: edge pulse on line 5
    tag = "R2";
    req_v[5] = 1'b1; idle(1);
    req_v[5] = 1'b0; idle(2);
    step(1'b1, 1'b0, 2'd0, 8'd0);
    check("R2", vec_w, 8'h25, "edge vector");
    idle(1);

    // R4 / R11: three primary lines, chained
    tag = "R4";
    req_v[6] = 1'b1; req_v[4] = 1'b1; req_v[1] = 1'b1; idle(1);
    req_v = '0;
    tag = "R11";
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R4", vec_w, 8'h21, "first winner");
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R4", vec_w, 8'h24, "second winner");
    check("R11", {7'd0, int_w}, 8'd1, "int stays high");
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R4", vec_w, 8'h26, "third winner");
    idle(1);

    // R6: cascade ordering
    tag = "R6";
    req_v[11] = 1'b1; req_v[4] = 1'b1; idle(1); req_v = '0;
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R6", vec_w, 8'h7B, "secondary beats line 4");
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R6", vec_w, 8'h24, "line 4 after");
    req_v[0] = 1'b1; req_v[9] = 1'b1; idle(1); req_v = '0;
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R6", vec_w, 8'h20, "line 0 beats secondary");
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R6", vec_w, 8'h79, "secondary line 9");
    idle(1);

    // R10: request pin 2 ignored
    tag = "R10";
    req_v[2] = 1'b1; idle(2);
    check("R10", {7'd0, int_w}, 8'd0, "pin 2 no int");
    req_v[2] = 1'b0; idle(1);

    // R9 / R3: masked trigger registers
    tag = "R9";
    step(1'b0, 1'b1, 2'd2, 8'hFF);
    step(1'b0, 1'b1, 2'd3, 8'hFF);
    req_v[0] = 1'b1; req_v[3] = 1'b1; idle(1);
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R9", vec_w, 8'h20, "line 0 edge only");
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R3", vec_w, 8'h23, "level line");
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R3", vec_w, 8'h23, "level line again");
    req_v = '0; idle(1);
    check("R3", {7'd0, int_w}, 8'd0, "level drop clears");
    req_v[8] = 1'b1; req_v[9] = 1'b1; req_v[13] = 1'b1; idle(1);
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R9", vec_w, 8'h78, "line 8 edge");
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R9", vec_w, 8'h79, "line 9 level");
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R9", vec_w, 8'h79, "line 9 held");
    req_v[9] = 1'b0; idle(1);
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R9", vec_w, 8'h7D, "line 13 edge");
    req_v = '0; idle(1);
    check("R9", {7'd0, int_w}, 8'd0, "all clear");
    step(1'b0, 1'b1, 2'd2, 8'h00);
    step(1'b0, 1'b1, 2'd3, 8'h00);

    // R12: new edge on the acknowledge cycle
    tag = "R12";
    req_v[6] = 1'b1; idle(1); req_v[6] = 1'b0; idle(1);
    req_v[6] = 1'b1;
    step(1'b1, 1'b0, 2'd0, 8'd0); check("R12", vec_w, 8'h26, "acked");
    check("R12", {7'd0, int_w}, 8'd1, "re-pending");
    req_v = '0; drain(); idle(1);

    // R5: seeded random traffic
    tag = "R5";
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] flip;
      flip = 16'($urandom) & 16'($urandom) & 16'($urandom);
      req_v = req_v ^ flip;
      step(($urandom % 4) == 0, ($urandom % 32) == 0, 2'($urandom), 8'($urandom));
    end
    req_v = '0; idle(2); drain();
    finish_run();
  end
endmodule